// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block saves an 8-bit processor's working context to a byte-wide stack when an interrupt is taken, and brings it back when the handler returns. It owns a 16-bit stack pointer. On a save request it takes a snapshot of the program counter, the low index byte, the accumulator and the condition code byte. It then writes them one byte per cycle into memory below the current stack top. On a restore request it reads the same five bytes back, last-written first. It then presents them on its restored-value outputs.

Each stack byte goes through one synchronous memory port. A write completes at the clock edge that ends the write cycle. A read returns its data on `mem_rdata` in the cycle after the read cycle. The memory always accepts an access, so the port has no back-pressure and needs no ready signal. The requests, `busy` and `done` are plain control pins. A request is taken only in a cycle where `busy` is low. Nothing upstream has to hold a request.

Top module: `irq_ctx_stacker`

## Requirements
- R1: After reset, `sp_out` is 0x00FF, `busy` and `done` are 0, no memory access is issued, and `ccr_out` reads 0x60.
- R2: A save writes each byte to the address held in the stack pointer and then decrements the pointer. Its five writes therefore go to addresses SP, SP-1, SP-2, SP-3 and SP-4 in consecutive cycles.
- R3: A save writes its bytes in this order: program counter bits 7:0, program counter bits 15:8, index low byte, accumulator, then the condition code byte. The condition code byte is written with bits 6 and 5 set.
- R4: A restore first increments the stack pointer and then reads at the new address. Its reads go to SP+1 through SP+5 in consecutive cycles. They deliver, in that order, the condition code byte, the accumulator, the index low byte, the program counter high byte and the program counter low byte.
- R5: A frame is exactly five bytes and holds no upper index byte. Each save lowers `sp_out` by 5 and each restore raises it by 5.
- R6: After a restore, bits 6 and 5 of `ccr_out` are 1 whatever byte the memory returned. The other bits equal the returned byte.
- R7: When a save completes, `ccr_out` equals the snapshot condition code byte with bit 3 (interrupt mask) and bits 6 and 5 set.
- R8: `busy` is high for exactly five cycles, starting in the cycle after an accepted request. A memory write (save) or read (restore) is issued in every one of those cycles and in no other cycle. Requests that arrive while `busy` is high are ignored.
- R9: When save and restore are requested in the same idle cycle, the save is performed and the restore is dropped.
- R10: Stack pointer arithmetic wraps modulo 2^16. A save crossing 0x0000 continues at 0xFFFF, and a restore crossing 0xFFFF continues at 0x0000.
- R11: `done` is a one-cycle pulse. For a save it comes in the cycle after the last write. For a restore it comes in the cycle after the last read data is returned. All restored values are valid in the `done` cycle and held until the next sequence changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Request to stack the context (interrupt entry) |
| restore_req | input | 1 | Request to unstack the context (interrupt return) |
| pc_in | input | 16 | Program counter snapshot, taken with an accepted save |
| x_in | input | 8 | Index low byte snapshot |
| a_in | input | 8 | Accumulator snapshot |
| ccr_in | input | 8 | Condition code snapshot |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_wdata | output | 8 | Stack memory write data |
| mem_re | output | 1 | Stack memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored index low byte |
| a_out | output | 8 | Restored accumulator |
| ccr_out | output | 8 | Restored condition codes, or updated codes after a save |

## Verification
A stack pointer that is off by one shows up at `mem_addr` on the very first access of the next sequence. Because the save uses store-then-decrement and the restore uses increment-then-load, a restore placed right after a save of known bytes exposes any mismatch in its first read. A wrong slot counter or a byte-order swap shows up within the same five-cycle window, either as a wrong `mem_wdata` or as a field landing in the wrong output. Pushing enough frames to cross address 0x0000 and then draining them in reverse checks the wrap and byte order across a long nesting.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  // byte-wide stack; a frame is five bytes
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BYTES = 5;
  localparam int unsigned SLOT_W      = $clog2(FRAME_BYTES);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BYTES - 1);

  // condition code bits that always read as one, and the interrupt mask
  localparam logic [BYTE_W-1:0] CCR_FIXED_ONES = 8'h60;
  localparam logic [BYTE_W-1:0] CCR_IMASK      = 8'h08;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_SAVE    = 2'd1,
    OP_RESTORE = 2'd2
  } ctx_op_e;

endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_down,
  input  logic              step_up,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_up
);

  // modulo-2^ADDR_W arithmetic falls out of the fixed width
  assign sp_up = sp + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= SP_RESET;
    end else if (step_down) begin
      sp <= sp - ADDR_W'(1);
    end else if (step_up) begin
      sp <= sp_up;
    end
  end

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_down && step_up));

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              restore_req,
  output ctx_op_e           op,
  output logic [SLOT_W-1:0] slot,
  output logic              busy,
  output logic              last
);

  assign busy = (op != OP_IDLE);
  assign last = busy && (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op   <= OP_IDLE;
      slot <= '0;
    end else if (!busy) begin
      slot <= '0;
      // save wins a same-cycle collision
      if (save_req)         op <= OP_SAVE;
      else if (restore_req) op <= OP_RESTORE;
    end else if (last) begin
      op   <= OP_IDLE;
      slot <= '0;
    end else begin
      slot <= slot + SLOT_W'(1);
    end
  end

  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= LAST_SLOT));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(op)));

  assert_ends_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

endmodule

// File: rtl/ctx_frame.sv
module ctx_frame
  import ctx_stack_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] ccr_in,
  input  ctx_op_e           op,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [PC_W-1:0]   pc_out,
  output logic [BYTE_W-1:0] x_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [BYTE_W-1:0] ccr_out,
  output logic              done
);

  localparam int unsigned PC_BYTES = PC_W / BYTE_W;

  logic [PC_W-1:0]   snap_pc;
  logic [BYTE_W-1:0] snap_x, snap_a, snap_ccr;
  logic [BYTE_W-1:0] frame [FRAME_BYTES];
  logic              rd_vld_q;
  logic [SLOT_W-1:0] rd_slot_q;
  logic              save_last;
  logic              restore_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_pc  <= '0;
      snap_x   <= '0;
      snap_a   <= '0;
      snap_ccr <= '0;
    end else if (capture) begin
      snap_pc  <= pc_in;
      snap_x   <= x_in;
      snap_a   <= a_in;
      snap_ccr <= ccr_in;
    end
  end

  // frame layout in push order: pc bytes low first, index, accumulator, codes
  for (genvar g = 0; g < PC_BYTES; g++) begin : g_pc_bytes
    assign frame[g] = snap_pc[g*BYTE_W +: BYTE_W];
  end
  assign frame[PC_BYTES]     = snap_x;
  assign frame[PC_BYTES + 1] = snap_a;
  assign frame[PC_BYTES + 2] = snap_ccr | CCR_FIXED_ONES;

  always_comb begin
    wr_byte = '0;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (slot == SLOT_W'(i)) wr_byte = frame[i];
    end
  end

  assign save_last    = (op == OP_SAVE) && (slot == LAST_SLOT);
  assign restore_last = rd_vld_q && (rd_slot_q == LAST_SLOT);

  // read data returns one cycle after the read, tagged by its slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_slot_q <= '0;
      done      <= 1'b0;
    end else begin
      rd_vld_q  <= (op == OP_RESTORE);
      rd_slot_q <= slot;
      done      <= save_last || restore_last;
    end
  end

  // pull order is the reverse of push order
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out  <= '0;
      x_out   <= '0;
      a_out   <= '0;
      ccr_out <= CCR_FIXED_ONES;
    end else if (rd_vld_q) begin
      case (rd_slot_q)
        SLOT_W'(0): ccr_out <= rd_byte | CCR_FIXED_ONES;
        SLOT_W'(1): a_out   <= rd_byte;
        SLOT_W'(2): x_out   <= rd_byte;
        SLOT_W'(3): pc_out[PC_W-1 -: BYTE_W] <= rd_byte;
        SLOT_W'(4): pc_out[BYTE_W-1:0]       <= rd_byte;
        default: ;
      endcase
    end else if (save_last) begin
      ccr_out <= snap_ccr | CCR_FIXED_ONES | CCR_IMASK;
    end
  end

  assert_ccr_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ccr_out[6:5] == 2'b11));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    save_last |=> (done && ccr_out[3]));

endmodule

// File: rtl/irq_ctx_stacker.sv
module irq_ctx_stacker
  import ctx_stack_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic [15:0]       pc_in,
  input  logic [7:0]        x_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        ccr_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp_out,
  output logic [15:0]       pc_out,
  output logic [7:0]        x_out,
  output logic [7:0]        a_out,
  output logic [7:0]        ccr_out
);

  ctx_op_e           op;
  logic [SLOT_W-1:0] slot;
  logic              last;
  logic [ADDR_W-1:0] sp_up;

  ctx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .op          (op),
    .slot        (slot),
    .busy        (busy),
    .last        (last)
  );

  ctx_sp_reg #(
    .ADDR_W   (ADDR_W),
    .SP_RESET (SP_RESET)
  ) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_down (mem_we),
    .step_up   (mem_re),
    .sp        (sp_out),
    .sp_up     (sp_up)
  );

  ctx_frame #(
    .PC_W (16)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (!busy && save_req),
    .pc_in   (pc_in),
    .x_in    (x_in),
    .a_in    (a_in),
    .ccr_in  (ccr_in),
    .op      (op),
    .slot    (slot),
    .rd_byte (mem_rdata),
    .wr_byte (mem_wdata),
    .pc_out  (pc_out),
    .x_out   (x_out),
    .a_out   (a_out),
    .ccr_out (ccr_out),
    .done    (done)
  );

  // store-then-decrement on save, increment-then-load on restore
  assign mem_we   = (op == OP_SAVE);
  assign mem_re   = (op == OP_RESTORE);
  assign mem_addr = mem_re ? sp_up : sp_out;

  assert_write_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ADDR_W'(1)));

  assert_read_ascends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_access_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_busy_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (mem_we || mem_re));

  assert_sp_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(sp_out));

endmodule

// File: tb/test_irq_ctx_stacker.sv
module test_irq_ctx_stacker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        save_req = 1'b0, restore_req = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [15:0] sp_out, pc_out;
  logic [7:0]  x_out, a_out, ccr_out;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_sp;
  logic [7:0]  mem [logic [15:0]];

  always #5 clk = ~clk;

  irq_ctx_stacker i_irq_ctx_stacker (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .sp_out(sp_out), .pc_out(pc_out), .x_out(x_out), .a_out(a_out),
    .ccr_out(ccr_out)
  );

  // synchronous byte memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_pc(int n);  return 16'(16'hA000 + n * 257); endfunction
  function automatic logic [7:0]  f_x(int n);   return 8'(n * 3 + 1);          endfunction
  function automatic logic [7:0]  f_a(int n);   return 8'(~n);                 endfunction
  function automatic logic [7:0]  f_ccr(int n); return 8'(n * 37);             endfunction

  task automatic do_save(input logic [15:0] pc, input logic [7:0] x, a, ccr,
                         input bit both, input bit inject);
    logic [7:0] exp_b [5];
    exp_b[0] = pc[7:0]; exp_b[1] = pc[15:8]; exp_b[2] = x; exp_b[3] = a;
    exp_b[4] = ccr | 8'h60;
    @(negedge clk);
    pc_in = pc; x_in = x; a_in = a; ccr_in = ccr;
    save_req = 1'b1; restore_req = both;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    pc_in = ~pc; x_in = ~x;
    for (int i = 0; i < 5; i++) begin
      if (inject && i == 2) begin save_req = 1'b1; restore_req = 1'b1; end
      chk("R8", "busy during save", 32'(busy), 32'd1);
      chk(both ? "R9" : "R8", "write strobe", 32'({mem_we, mem_re}), 32'h2);
      chk(i == 0 ? "R2" : "R10", "write addr", 32'(mem_addr), 32'(16'(exp_sp - 16'(i))));
      chk("R3", "write byte", 32'(mem_wdata), 32'(exp_b[i]));
      @(negedge clk);
      save_req = 1'b0; restore_req = 1'b0;
    end
    chk("R11", "save done", 32'(done), 32'd1);
    chk("R8", "idle after save", 32'({busy, mem_we, mem_re}), 32'd0);
    chk("R7", "ccr after save", 32'(ccr_out), 32'(ccr | 8'h68));
    exp_sp = 16'(exp_sp - 16'd5);
    chk("R5", "sp after save", 32'(sp_out), 32'(exp_sp));
    @(negedge clk);
    chk("R8", "ignored request left idle", 32'({busy, done, mem_we, mem_re}), 32'd0);
  endtask

  task automatic do_restore(input logic [15:0] pc, input logic [7:0] x, a, ccr_exp);
    @(negedge clk);
    restore_req = 1'b1;
    @(negedge clk);
    restore_req = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R8", "busy during restore", 32'(busy), 32'd1);
      chk("R4", "read strobe", 32'({mem_we, mem_re}), 32'h1);
      chk(i == 0 ? "R4" : "R10", "read addr", 32'(mem_addr), 32'(16'(exp_sp + 16'(i + 1))));
      @(negedge clk);
    end
    chk("R11", "no done before data", 32'({busy, done}), 32'd0);
    @(negedge clk);
    chk("R11", "restore done", 32'(done), 32'd1);
    chk("R4", "pc restored", 32'(pc_out), 32'(pc));
    chk("R4", "x restored", 32'(x_out), 32'(x));
    chk("R4", "a restored", 32'(a_out), 32'(a));
    chk("R6", "ccr restored", 32'(ccr_out), 32'(ccr_exp));
    exp_sp = 16'(exp_sp + 16'd5);
    chk("R5", "sp after restore", 32'(sp_out), 32'(exp_sp));
    @(negedge clk);
    chk("R11", "done single, values held", 32'({done, pc_out, x_out}), 32'({1'b0, pc, x}));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    exp_sp = 16'h00FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset sp", 32'(sp_out), 32'h00FF);
    chk("R1", "reset control", 32'({busy, done, mem_we, mem_re}), 32'd0);
    chk("R1", "reset ccr", 32'(ccr_out), 32'h60);

    // single round trip
    do_save(16'h1234, 8'h56, 8'h78, 8'h03, 1'b0, 1'b0);
    do_restore(16'h1234, 8'h56, 8'h78, 8'h63);

    // deep nesting across the 0x0000 boundary, then drain in reverse
    for (int n = 0; n < 52; n++)
      do_save(f_pc(n), f_x(n), f_a(n), f_ccr(n), 1'b0, n == 10);
    chk("R10", "sp wrapped", 32'(sp_out), 32'hFFFB);
    for (int n = 51; n >= 0; n--)
      do_restore(f_pc(n), f_x(n), f_a(n), f_ccr(n) | 8'h60);
    chk("R10", "sp back at top", 32'(sp_out), 32'h00FF);

    // same-cycle save and restore: save wins
    do_save(16'hBEEF, 8'hC3, 8'h3C, 8'h91, 1'b1, 1'b0);
    // corrupt the stacked code byte: fixed bits must still read one
    mem[16'(exp_sp + 16'd1)] = 8'h00;
    do_restore(16'hBEEF, 8'hC3, 8'h3C, 8'h60);
    do_save(16'h0F0F, 8'h00, 8'hFF, 8'h9F, 1'b0, 1'b0);
    mem[16'(exp_sp + 16'd1)] = 8'h9F;
    do_restore(16'h0F0F, 8'h00, 8'hFF, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule